// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block performs the tag lookup for a two-way set-associative cache and keeps one prediction bit for each set, naming the way that the next access to that set is expected to hit. When a request is accepted, only the predicted way's tag and data arrays are enabled and compared. If that tag matches, the data returns one cycle later. Reading one way instead of two saves array read energy on the common path.

When the prediction is wrong, the block spends one more cycle enabling and comparing both ways. A match there is reported as a slow hit, and the set's prediction is moved to the way that hit. When neither way matches, the block raises a refill request for the missing address. It writes the returned line into a victim way and answers the request with that data, flagged as a miss. One LRU bit per set picks the victim once both ways hold valid lines. A fast/slow flag on every response lets the requester count mispredictions.

Requests use a valid/ready handshake. Responses are single-cycle pulses. The refill port is a request level that the memory side answers with one data beat.

Top module: `wp_cache_lookup`

## Requirements
- R1: After synchronous active-low reset, req_ready is 1, and rsp_valid and fill_req are 0. Every line is invalid and every prediction and LRU bit is 0, so the first access to any set is a miss. A reset in mid-run discards all cached lines in the same way.
- R2: When the predicted way holds a valid line with a matching tag, rsp_valid pulses in the cycle after acceptance. The pulse carries rsp_hit=1, rsp_fast=1, rsp_way equal to the predicted way, and that way's stored data.
- R3: In the acceptance cycle, exactly one way's tag/data arrays are read-enabled: the predicted one.
- R4: When the predicted way misses and the other way matches, rsp_valid pulses two cycles after acceptance. The pulse carries rsp_hit=1, rsp_fast=0, that way and its data. The set's prediction then points to that way.
- R5: When neither way matches, fill_req rises two cycles after acceptance and holds, with fill_addr equal to the request address, until a cycle with fill_valid=1. req_ready stays 0 meanwhile.
- R6: In the fill_valid cycle, fill_data is written into the victim way, and rsp_valid pulses one cycle later. The pulse carries rsp_hit=0, rsp_fast=0, rsp_way equal to the victim, and rsp_data equal to fill_data. The prediction then points to the victim.
- R7: The victim is the first invalid way (way 0 before way 1). If both ways are valid, the victim is the least recently used way, where every hit or fill makes its way the most recent.
- R8: req_ready is 1 only while no lookup is in progress. Consecutive fast hits are accepted on back-to-back cycles, each answered the following cycle.
- R9: fill_valid has no effect while fill_req is 0.
- R10: The set index is the low IDX_W bits of req_addr and the tag is the remaining upper bits. Sets keep independent lines, predictions and LRU state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Request address {tag, set index} |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 = line was present, 0 = answered by refill |
| rsp_fast | output | 1 | 1 = hit in the predicted way |
| rsp_way | output | 1 | Way that supplied or received the line |
| rsp_data | output | DATA_W | Line data |
| fill_req | output | 1 | Refill requested for fill_addr |
| fill_addr | output | ADDR_W | Address being refilled |
| fill_valid | input | 1 | Refill data present this cycle |
| fill_data | input | DATA_W | Refill data |

## Verification
The assertions assume a memory side that answers each fill_req with exactly one fill_valid beat and keeps fill_data valid in that cycle. They also assume a requester that needs no response backpressure. Stray fill_valid pulses outside a refill are permitted, and the checks are written to tolerate them. The stimulus keeps within these limits. It answers every refill with a single beat after a fixed delay. It raises req_valid only while req_ready is high and never stalls a response. The one exception is a deliberate idle-time fill_valid burst, which exercises the ignore rule.

// File: rtl/wp_pkg.sv
// Shared definitions for the way-predicting lookup.
// Assumes a fixed associativity of two ways.
package wp_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // accepting; predicted-way probe
        ST_FULL = 2'd1,   // both ways compared
        ST_FILL = 2'd2    // waiting for refill data
    } lk_state_e;
endpackage

// File: rtl/wp_way_array.sv
// One way of the cache: valid bits, tags and data per set.
// Tag and data reads are gated by rd_en so that a way that is not probed
// presents zeros (the power-saving read). Valid bits are always visible
// because the victim choice needs them. Writes are single-cycle.
module wp_way_array #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data storage: written on fill, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    // Gated read ports.
    always_comb begin
        valid_o = vld_q[rd_idx];
        tag_o   = rd_en ? tag_q[rd_idx] : '0;
        data_o  = rd_en ? dat_q[rd_idx] : '0;
    end
endmodule

// File: rtl/wp_hint_table.sv
// Per-set prediction bit and LRU bit.
// An update marks upd_way as both predicted and most recently used,
// so the LRU bit then names the other way.
module wp_hint_table #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             pred_o,
    output logic             lru_o,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    // Hint storage: cleared on reset, rewritten on every hit or fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (upd_en) begin
            pred_q[upd_idx] <= upd_way;
            lru_q[upd_idx]  <= ~upd_way;
        end
    end

    // Read of the current set's hints.
    always_comb begin
        pred_o = pred_q[rd_idx];
        lru_o  = lru_q[rd_idx];
    end
endmodule

// File: rtl/wp_lookup_ctrl.sv
// Lookup sequencer: probes the predicted way in the acceptance cycle,
// falls back to a two-way compare, and handles refill on a miss.
// Assumes match_w comes from gated array reads of rd_idx/cmp_tag in the
// same cycle, and that no response backpressure exists.
module wp_lookup_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        req_ready,
    output logic [IDX_W-1:0]            rd_idx,
    output logic [TAG_W-1:0]            cmp_tag,
    output logic [WAYS-1:0]             rd_en,
    output logic [WAYS-1:0]             wr_en,
    input  logic [WAYS-1:0]             valid_w,
    input  logic [WAYS-1:0]             match_w,
    input  logic [WAYS-1:0][DATA_W-1:0] data_w,
    input  logic                        pred,
    input  logic                        lru,
    output logic                        upd_en,
    output logic                        upd_way,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic                        rsp_fast,
    output logic                        rsp_way,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        fill_req,
    output logic [ADDR_W-1:0]           fill_addr,
    input  logic                        fill_valid,
    input  logic [DATA_W-1:0]           fill_data
);
    lk_state_e         state_q;
    logic [ADDR_W-1:0] hold_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              victim;
    logic              fast_hit;
    logic              late_hit;
    logic              fill_done;

    // Address under lookup: live request when idle, held copy otherwise.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? req_addr : hold_q;
        rd_idx   = cur_addr[IDX_W-1:0];
        cmp_tag  = cur_addr[ADDR_W-1:IDX_W];
    end

    // Read enables: predicted way only on the probe, both on the full compare.
    always_comb begin
        rd_en = '0;
        case (state_q)
            ST_IDLE: if (req_valid) rd_en[pred] = 1'b1;
            ST_FULL: rd_en = '1;
            default: rd_en = '0;
        endcase
    end

    // Outcome decode and victim choice.
    always_comb begin
        fast_hit  = (state_q == ST_IDLE) && req_valid && match_w[pred];
        late_hit  = (state_q == ST_FULL) && (|match_w);
        fill_done = (state_q == ST_FILL) && fill_valid;
        if (!valid_w[0])      victim = 1'b0;
        else if (!valid_w[1]) victim = 1'b1;
        else                  victim = lru;
    end

    // Hint update and fill write strobes.
    always_comb begin
        upd_en  = fast_hit || late_hit || fill_done;
        upd_way = pred;
        if (late_hit)  upd_way = match_w[1];
        if (fill_done) upd_way = victim;
        wr_en = '0;
        if (fill_done) wr_en[victim] = 1'b1;
    end

    // Handshake and refill outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        fill_req  = (state_q == ST_FILL);
        fill_addr = hold_q;
    end

    // Sequencer state and held address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid && !match_w[pred]) begin
                    hold_q  <= req_addr;
                    state_q <= ST_FULL;
                end
                ST_FULL: state_q <= (|match_w) ? ST_IDLE : ST_FILL;
                ST_FILL: if (fill_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered response, one pulse per completed lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fast  <= 1'b0;
            rsp_way   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fast_hit || late_hit || fill_done;
            if (fast_hit) begin
                rsp_hit  <= 1'b1;
                rsp_fast <= 1'b1;
                rsp_way  <= pred;
                rsp_data <= data_w[pred];
            end else if (late_hit) begin
                rsp_hit  <= 1'b1;
                rsp_fast <= 1'b0;
                rsp_way  <= match_w[1];
                rsp_data <= data_w[match_w[1]];
            end else if (fill_done) begin
                rsp_hit  <= 1'b0;
                rsp_fast <= 1'b0;
                rsp_way  <= victim;
                rsp_data <= fill_data;
            end
        end
    end
endmodule

// File: rtl/wp_cache_lookup.sv
// Top of the way-predicting two-way lookup. Instantiates one array per way
// through a generate loop, the hint table and the sequencer, and forms the
// per-way tag match from the gated array reads.
// Assumes: one refill beat per fill_req, no response backpressure.
module wp_cache_lookup
    import wp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fast,
    output logic              rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]            rd_idx;
    logic [TAG_W-1:0]            cmp_tag;
    logic [WAYS-1:0]             rd_en;
    logic [WAYS-1:0]             wr_en;
    logic [WAYS-1:0]             valid_w;
    logic [WAYS-1:0]             match_w;
    logic [WAYS-1:0][TAG_W-1:0]  tag_w;
    logic [WAYS-1:0][DATA_W-1:0] data_w;
    logic                        pred;
    logic                        lru;
    logic                        upd_en;
    logic                        upd_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wp_way_array #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_arr (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (rd_en[w]),
            .rd_idx (rd_idx),
            .wr_en  (wr_en[w]),
            .wr_idx (rd_idx),
            .wr_tag (cmp_tag),
            .wr_data(fill_data),
            .valid_o(valid_w[w]),
            .tag_o  (tag_w[w]),
            .data_o (data_w[w])
        );

        // Tag match counts only for a way that was actually read.
        always_comb match_w[w] = rd_en[w] && valid_w[w] && (tag_w[w] == cmp_tag);
    end

    wp_hint_table #(.IDX_W(IDX_W)) u_hint (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .pred_o (pred),
        .lru_o  (lru),
        .upd_en (upd_en),
        .upd_idx(rd_idx),
        .upd_way(upd_way)
    );

    wp_lookup_ctrl #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rd_idx    (rd_idx),
        .cmp_tag   (cmp_tag),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .valid_w   (valid_w),
        .match_w   (match_w),
        .data_w    (data_w),
        .pred      (pred),
        .lru       (lru),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_fast  (rsp_fast),
        .rsp_way   (rsp_way),
        .rsp_data  (rsp_data),
        .fill_req  (fill_req),
        .fill_addr (fill_addr),
        .fill_valid(fill_valid),
        .fill_data (fill_data)
    );
endmodule

// File: rtl/wp_lookup_chk.sv
// Protocol checker for wp_cache_lookup, attached by bind below.
// Assumes the memory side answers each refill with one fill_valid beat.
module wp_lookup_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fast,
    input logic              fill_req,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [1:0]        rd_en
);
    // R3
    probe_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> $onehot(rd_en));

    // R2
    fast_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fast) |-> rsp_hit);

    // R4
    slow_hit_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_fast) |-> $past(!req_ready));

    // R5
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready);

    // R6
    fill_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |=> (rsp_valid && !rsp_hit && !rsp_fast && !fill_req));
endmodule

bind wp_cache_lookup wp_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fast  (rsp_fast),
    .fill_req  (fill_req),
    .fill_valid(fill_valid),
    .fill_addr (fill_addr),
    .rd_en     (rd_en)
);

// File: tb/sim_wp_cache_lookup.sv
`timescale 1ns/1ps
// Bench: a vector table of accesses with expected outcome, then directed
// tests for reset, back-to-back hits and stray refill beats.
module sim_wp_cache_lookup;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = 4;
    localparam int DATA_W   = 32;
    localparam int FILL_DLY = 3;
    localparam int NVEC     = 14;

    // kind: 0 = miss/refill, 1 = fast hit, 2 = slow hit
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        logic              way;
    } vec_t;

    // Set 1: A=0x011 B=0x021 C=0x031; set 2: D=0x012
    localparam vec_t VECS [NVEC] = '{
        '{12'h011, 2'd0, 1'b0},  // A miss -> way0 (R1, R7 invalid first)
        '{12'h011, 2'd1, 1'b0},  // A fast
        '{12'h021, 2'd0, 1'b1},  // B miss -> way1 (R7 second invalid)
        '{12'h021, 2'd1, 1'b1},  // B fast
        '{12'h011, 2'd2, 1'b0},  // A slow, pred -> 0
        '{12'h011, 2'd1, 1'b0},  // A fast
        '{12'h031, 2'd0, 1'b1},  // C miss, LRU way1 evicts B (R7)
        '{12'h021, 2'd0, 1'b0},  // B miss, LRU way0 evicts A (R7)
        '{12'h031, 2'd2, 1'b1},  // C slow
        '{12'h031, 2'd1, 1'b1},  // C fast
        '{12'h012, 2'd0, 1'b0},  // D in set 2 miss (R10)
        '{12'h021, 2'd2, 1'b0},  // B slow, set 1 untouched by D (R10)
        '{12'h012, 2'd1, 1'b0},  // D fast
        '{12'h021, 2'd1, 1'b0}   // B fast
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_fast, rsp_way;
    logic [DATA_W-1:0] rsp_data;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    wp_cache_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fast(rsp_fast), .rsp_way(rsp_way), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_data(fill_data)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [DATA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {8'hC5, 12'h0E7, a};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; answers a refill after FILL_DLY cycles; returns outcome.
    task automatic access(input logic [ADDR_W-1:0] a,
                          output logic hit, output logic fast, output logic way,
                          output logic [DATA_W-1:0] data, output int lat);
        int wait_n = 0;
        bit got = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        lat = 0;
        @(posedge clk);
        for (int k = 0; k < 30 && !got; k++) begin
            @(negedge clk);
            req_valid  = 1'b0;
            fill_valid = 1'b0;
            lat = lat + 1;
            if (rsp_valid) begin
                got  = 1;
                hit  = rsp_hit;
                fast = rsp_fast;
                way  = rsp_way;
                data = rsp_data;
            end else if (fill_req) begin
                wait_n = wait_n + 1;
                // R5: refill address and stalled handshake
                chk(fill_addr == a, "R5 fill_addr", fill_addr, a);
                chk(req_ready == 1'b0, "R5 req_ready low", req_ready, 0);
                if (wait_n == FILL_DLY) begin
                    fill_valid = 1'b1;
                    fill_data  = line_of(fill_addr);
                end
            end
        end
        if (!got) begin
            chk(0, "R2 no response", 0, 1);
            hit = 0; fast = 0; way = 0; data = '0;
        end
    endtask

    initial begin
        logic h, f, w;
        logic [DATA_W-1:0] d;
        int lat;
        string rq;
        int exp_lat;

        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(fill_req == 1'b0, "R1 fill_req", fill_req, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].addr, h, f, w, d, lat);
            case (VECS[i].kind)
                2'd0:    begin rq = "R6 miss"; exp_lat = 3 + FILL_DLY - 1; end
                2'd1:    begin rq = "R2 fast"; exp_lat = 1; end
                default: begin rq = "R4 slow"; exp_lat = 2; end
            endcase
            chk(h == (VECS[i].kind != 2'd0), rq, h, VECS[i].kind != 2'd0);
            chk(f == (VECS[i].kind == 2'd1), rq, f, VECS[i].kind == 2'd1);
            chk(w == VECS[i].way, {rq, " way R7"}, w, VECS[i].way);
            chk(d == line_of(VECS[i].addr), {rq, " data"}, d, line_of(VECS[i].addr));
            chk(lat == exp_lat, {rq, " latency R3"}, lat, exp_lat);
        end

        // R9: stray refill beats while idle must not disturb set 1 (B in way0)
        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        fill_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R9 no response", rsp_valid, 0);
        access(12'h021, h, f, w, d, lat);
        chk(h && f && lat == 1, "R9 still fast hit", {h, f}, 2'b11);
        chk(d == line_of(12'h021), "R9 data intact", d, line_of(12'h021));

        // R8: back-to-back fast hits D then B
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 12'h012;
        @(negedge clk);
        chk(rsp_valid && rsp_fast && rsp_data == line_of(12'h012), "R8 first",
            rsp_data, line_of(12'h012));
        chk(req_ready == 1'b1, "R8 ready", req_ready, 1);
        req_addr = 12'h021;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_fast && rsp_data == line_of(12'h021), "R8 second",
            rsp_data, line_of(12'h021));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 single pulse", rsp_valid, 0);

        // R1: mid-run reset discards cached lines
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && fill_req == 1'b0,
            "R1 mid reset outputs", {req_ready, rsp_valid, fill_req}, 3'b100);
        rst_n = 1'b1;
        access(12'h021, h, f, w, d, lat);
        chk(h == 1'b0 && w == 1'b0, "R1 miss after reset", {h, w}, 2'b00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule